// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when the rows of a DRAM array must be refreshed and drives the strobe sequence that refreshes them. A free-running interval timer raises a refresh need. The scheduler then asks the access sequencer for the command bus, waits for the grant, and runs the refresh while it owns the bus. When the refresh is over it lets the bus go. The `busy` output is high for the whole refresh so that normal accesses are held off. The memory cannot be reached during that time.

Two configuration inputs pick the refresh style and the command form.

- **Distributed style:** one row is refreshed each time the short per-row interval ends. That interval is the retention period divided by the row count.
- **Bursty style:** every row is refreshed back to back once per retention period.
- **Address-strobe-only form:** the row number comes from a counter inside this block and is driven onto the address lines. Only RAS is pulsed, and the counter then steps.
- **Column-first form:** CAS is lowered before RAS, WE stays high and no address is driven. The DRAM steps its own row counter.

All times are parameters in nanoseconds. They are turned into clock-cycle counts using the clock period parameter. With the default values (4096 rows, 64 ms retention, 100 ns row cycle, 5 ns clock), the timings are:

- one row every 3125 cycles in distributed style;
- one full pass every 12.8 million cycles in bursty style.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied and right after it, `bus_req`, `busy` and `addr_en` are 0, `ras_n`, `cas_n` and `we_n` are 1, and `row_addr` is 0.
- R2: With `mode_burst`=0, exactly one row refresh (one falling edge of `ras_n`) follows each expiry of the per-row interval of RET_CYC/ROWS cycles, counted from reset release.
- R3: With `mode_burst`=1, each expiry of the RET_CYC-cycle retention interval is followed by ROWS row refreshes run back to back in one bus tenure, each row taking ROW_CYC cycles.
- R4: With `mode_cbr`=0, `addr_en` is 1 and `cas_n` stays 1 for the whole refresh. `ras_n` is low for ROW_CYC-2 cycles per row. `row_addr` holds the internal counter value and is steady while `ras_n` is low. The counter steps by one after each row.
- R5: The internal row counter steps from ROWS-1 back to 0.
- R6: With `mode_cbr`=1, `cas_n` goes low one cycle before `ras_n` and stays low for ROW_CYC-1 cycles per row. `we_n` stays 1, `addr_en` stays 0, and the internal row counter does not change.
- R7: `bus_req` rises when the interval expires and stays high until the grant `bus_gnt` arrives. No strobe is driven before the grant. `busy` only rises in the cycle after `bus_gnt` was sampled high, and `bus_req` drops once all owed refreshes are done.
- R8: `busy` is 1 in every cycle where `ras_n` or `cas_n` is low, and `busy` implies `bus_req`.
- R9: An expiry that occurs while a refresh is still pending adds one owed refresh, up to 8 owed. After the grant, the pending refresh and every owed refresh are performed one after another, each followed by a single re-request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_burst | input | 1 | 1 selects bursty style, 0 selects distributed style |
| mode_cbr | input | 1 | 1 selects column-first refresh, 0 selects address-strobe-only refresh |
| bus_gnt | input | 1 | Bus grant from the access sequencer |
| bus_req | output | 1 | Bus request towards the access sequencer |
| busy | output | 1 | Refresh in progress; accesses must be blocked |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| addr_en | output | 1 | Row address on `row_addr` is being driven |
| row_addr | output | ROW_W | Internal refresh row counter |

## Verification
The hardest case to reach is saturation of the owed-refresh count. It only happens when the grant is withheld across more than nine interval expiries, and its effect shows only as the number of refreshes done afterwards.

The stimulus holds `bus_gnt` low for twelve distributed intervals. It then grants the bus just after an expiry and counts the RAS pulses before `bus_req` falls, expecting nine. The bench scales the timing down (8 rows, 4-cycle row slot, 800-cycle retention) so that both styles and the counter wrap fit in a short run.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROWS     = 4096,
  parameter int CLK_NS   = 5,
  parameter int ROW_NS   = 100,
  parameter int RET_NS   = 64_000_000,
  parameter int DEBT_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_burst,
  input  logic             mode_cbr,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             busy,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             addr_en,
  output logic [$clog2(ROWS)-1:0] row_addr
);
  localparam int ROW_W    = $clog2(ROWS);
  localparam int ROW_CYC  = ROW_NS / CLK_NS;
  localparam int RET_CYC  = RET_NS / CLK_NS;
  localparam int DIST_CYC = RET_CYC / ROWS;
  localparam int TMR_W    = $clog2(RET_CYC + 1);
  localparam int P_W      = $clog2(ROW_CYC);
  localparam int DEBT_W   = $clog2(DEBT_MAX + 1);

  typedef enum logic [1:0] {IDLE, REQ, RUN} state_t;

  state_t            state;
  logic [TMR_W-1:0]  timer;
  logic [P_W-1:0]    phase;
  logic [ROW_W-1:0]  row_q;
  logic [ROW_W-1:0]  rows_left;
  logic [DEBT_W-1:0] debt;
  logic              cbr_q;

  logic [TMR_W-1:0] interval;
  logic             tick, run, slot_end, done, debt_full;

  assign interval  = mode_burst ? TMR_W'(RET_CYC) : TMR_W'(DIST_CYC);
  assign tick      = timer >= interval - 1'b1;
  assign run       = state == RUN;
  assign slot_end  = phase == P_W'(ROW_CYC - 1);
  assign done      = run && slot_end && rows_left == '0;
  assign debt_full = debt >= DEBT_W'(DEBT_MAX);

  assign bus_req  = state != IDLE;
  assign busy     = run;
  assign ras_n    = !(run && phase >= P_W'(1) && phase <= P_W'(ROW_CYC - 2));
  assign cas_n    = !(run && cbr_q && phase <= P_W'(ROW_CYC - 2));
  assign we_n     = 1'b1;
  assign addr_en  = run && !cbr_q;
  assign row_addr = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      timer     <= '0;
      phase     <= '0;
      row_q     <= '0;
      rows_left <= '0;
      debt      <= '0;
      cbr_q     <= 1'b0;
    end else begin
      timer <= tick ? '0 : timer + 1'b1;
      case (state)
        IDLE: if (tick) state <= REQ;
        REQ: begin
          if (tick && !debt_full) debt <= debt + 1'b1;
          if (bus_gnt) begin
            state     <= RUN;
            phase     <= '0;
            cbr_q     <= mode_cbr;
            rows_left <= mode_burst ? ROW_W'(ROWS - 1) : '0;
          end
        end
        RUN: begin
          phase <= slot_end ? '0 : phase + 1'b1;
          if (slot_end && !cbr_q)
            row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
          if (slot_end && rows_left != '0) rows_left <= rows_left - 1'b1;
          if (done) begin
            if (debt != '0) begin
              state <= REQ;
              if (!tick) debt <= debt - 1'b1;
            end else begin
              state <= tick ? REQ : IDLE;
            end
          end else if (tick && !debt_full) begin
            debt <= debt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_gnt,
  input logic             bus_req,
  input logic             busy,
  input logic             ras_n,
  input logic             cas_n,
  input logic             addr_en,
  input logic [ROW_W-1:0] row_addr
);
  assert_strobe_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> busy);

  assert_busy_holds_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bus_req);

  assert_grant_before_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_gnt));

  assert_cas_leads_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  assert_no_addr_in_cbr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !addr_en);

  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && addr_en) |-> $stable(row_addr));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req), .busy(busy),
  .ras_n(ras_n), .cas_n(cas_n), .addr_en(addr_en), .row_addr(row_addr)
);

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
  localparam int ROWS    = 8;
  localparam int ROW_W   = 3;
  localparam int ROW_CYC = 4;
  localparam int RET_CYC = 800;
  localparam int DIST    = RET_CYC / ROWS;

  // {burst, cbr, ras falls[3:0], cas falls[3:0], end row[5:0]}
  localparam logic [15:0] VEC [4] = '{
    {1'b0, 1'b0, 4'd9, 4'd0, 6'd1},
    {1'b0, 1'b1, 4'd9, 4'd9, 6'd0},
    {1'b1, 1'b0, 4'd8, 4'd0, 6'd0},
    {1'b1, 1'b1, 4'd8, 4'd8, 6'd0}
  };

  logic clk = 0, rst_n = 0, mode_burst = 0, mode_cbr = 0, bus_gnt = 0;
  logic bus_req, busy, ras_n, cas_n, we_n, addr_en;
  logic [ROW_W-1:0] row_addr;

  int n_chk = 0, n_err = 0;
  int ras_falls = 0, cas_falls = 0, ras_len = 0, cas_len = 0, exp_row = 0;
  logic p_ras = 1, p_cas = 1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(.ROWS(ROWS), .CLK_NS(5), .ROW_NS(20), .RET_NS(4000)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst), .mode_cbr(mode_cbr),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .busy(busy), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr_en(addr_en), .row_addr(row_addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr_mon();
    ras_falls = 0; cas_falls = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    clr_mon();
    exp_row = 0;
    rst_n = 1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        ras_falls++;
        check(busy, "R8 busy during RAS", busy, 1);
        check(we_n, "R6 we_n high", we_n, 1);
        if (addr_en) begin
          check(row_addr == ROW_W'(exp_row), "R4/R5 row address", row_addr, exp_row);
          exp_row = (exp_row + 1) % ROWS;
        end else begin
          check(!cas_n && !p_cas, "R6 CAS before RAS", cas_n, 0);
        end
      end
      if (p_cas && !cas_n) begin
        cas_falls++;
        check(!addr_en, "R6 no address in CBR", addr_en, 0);
      end
      if (!ras_n) ras_len++;
      else if (!p_ras) begin
        check(ras_len == ROW_CYC - 2, "R4 RAS low width", ras_len, ROW_CYC - 2);
        ras_len = 0;
      end
      if (!cas_n) cas_len++;
      else if (!p_cas) begin
        check(cas_len == ROW_CYC - 1, "R6 CAS low width", cas_len, ROW_CYC - 1);
        cas_len = 0;
      end
    end else begin
      ras_len = 0; cas_len = 0;
    end
    p_ras = ras_n; p_cas = cas_n;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check(!bus_req && !busy && !addr_en, "R1 req/busy/addr_en low", {bus_req, busy, addr_en}, 0);
    check(ras_n && cas_n && we_n, "R1 strobes high", {ras_n, cas_n, we_n}, 7);
    check(row_addr == 0, "R1 row counter", row_addr, 0);

    // R2/R3/R4/R5/R6 table of mode combinations, grant always given
    for (int i = 0; i < 4; i++) begin
      mode_burst = VEC[i][15];
      mode_cbr   = VEC[i][14];
      bus_gnt    = 1;
      do_reset();
      repeat (950) @(negedge clk);
      check(ras_falls == int'(VEC[i][13:10]), mode_burst ? "R3 rows per pass" : "R2 rows per window",
            ras_falls, VEC[i][13:10]);
      check(cas_falls == int'(VEC[i][9:6]), mode_cbr ? "R6 CAS pulses" : "R4 no CAS pulses",
            cas_falls, VEC[i][9:6]);
      check(row_addr == ROW_W'(VEC[i][5:0]), mode_cbr ? "R6 counter unchanged" : "R5 counter wrap",
            row_addr, VEC[i][5:0]);
      check(!bus_req && !busy, "R7 bus released", {bus_req, busy}, 0);
    end

    // R7 no grant: request held, nothing driven
    mode_burst = 0; mode_cbr = 0; bus_gnt = 0;
    do_reset();
    repeat (150) @(negedge clk);
    check(bus_req, "R7 request raised", bus_req, 1);
    check(!busy, "R7 not busy without grant", busy, 0);
    check(ras_falls == 0 && cas_falls == 0, "R7 no strobes without grant", ras_falls, 0);

    // R9 owed refreshes saturate at 8
    repeat (1060) @(negedge clk);
    check(bus_req, "R7 request still held", bus_req, 1);
    clr_mon();
    bus_gnt = 1;
    repeat (60) @(negedge clk);
    check(ras_falls == 9, "R9 pending plus 8 owed", ras_falls, 9);
    check(!bus_req, "R7 release after debt", bus_req, 0);
    check(row_addr == 1, "R5 counter after 9 rows", row_addr, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule